// File: doc/BRIEF.md
# Multi-channel aligned PWM generator

This block generates pulse-width modulated outputs on a parameterised number of channels. Each channel's waveform is set by three counts, all in clock cycles: the period, the high time and the delay from the start of the period to the rising edge. Software programs these counts over a simple single-cycle register bus. The writes go into a staging copy, so they do not change the live waveforms. One global load command then transfers the staged counts of all channels to the live copy together.

A load also restarts every enabled channel at cycle index zero, so all outputs run in phase. With the align option set, the load takes effect on the clock edge that accepts the command. With the option clear, the transfer is held until every enabled channel has completed a full period since the command. The bank then switches over and restarts at that common boundary. A soft-reset bit in the control register, which is set out of reset, holds all counters and forces the outputs low. Identification, scratch and channel-count registers let software find and probe the block.

Bus reads return their data on the clock edge after the request. Addresses are byte addresses of 32-bit words and must be word aligned.

Top module: `pwm_bank`

## Requirements
- R1: The read-only registers return fixed values. Offset 0x00 returns version 0x00020100, so the major version 2 sits in bits [23:16]. Offset 0x04 returns the ID parameter, offset 0x0C returns 0x601A3471 and offset 0x14 returns NUM_CH.
- R2: Offset 0x08 is a 32-bit scratch register that reads back the last value written to it.
- R3: Offset 0x10 is the control register. Bit 0 is the soft-reset hold and is 1 after reset. Writing 1 to bit 1 issues a load, and bit 1 always reads 0. Offset 0x18 is the configuration register. Its bit 1 is the align option and is 0 after reset.
- R4: Channel n has its period at 0x40+4n, its high time at 0x80+4n and its delay at 0xC0+4n. These staged values read back as written and do not change pwm_o until a load is applied.
- R5: With align set, a load written on clock edge E copies all staged values to the live copy at E. Every enabled channel then sits at cycle index 0 in the cycle after E.
- R6: With live period P, high time D and delay O, pwm_o[n] is 1 at cycle index c (0..P-1) exactly when O <= c < O+D.
- R7: A high time larger than the period is clipped at the period end. For example, D >= P with O = 0 keeps the output high for the whole period.
- R8: A delay greater than or equal to the period gives no high time in any cycle.
- R9: A channel with live period 0, or any channel while control bit 0 is set, drives its output low.
- R10: With align clear, a load is held until each enabled channel has wrapped from P-1 to 0 after the load edge. On the edge of the last such wrap, the staged values are applied and all channels restart at index 0.
- R11: All outputs are low while rst_ni is low and right after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pwm_o | output | NUM_CH | PWM outputs, one per channel |

## Verification
The bench walks a table of period, high-time and delay settings through the live channel and compares every cycle of two periods against the window rule. This catches an off-by-one at the rising or falling edge, or a missing clip when the high time or the delay runs past the period end. A directed test changes only the staged copy. If a design leaks staged writes to the live copy, the waveform changes before the load is issued. A second directed test reloads two channels that have different periods, taken mid-period. A design that does not restart both counters shows unaligned edges. The deferred-load test issues the command on the very edge where the old period wraps. A design that counts that wrap, or that ignores the deferral altogether, switches one full period too early.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_VERSION = 8'h00;
  localparam logic [ADDR_W-1:0] A_IDENT   = 8'h04;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 8'h08;
  localparam logic [ADDR_W-1:0] A_MAGIC   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h10;
  localparam logic [ADDR_W-1:0] A_NCHAN   = 8'h14;
  localparam logic [ADDR_W-1:0] A_CONFIG  = 8'h18;

  localparam logic [DATA_W-1:0] VERSION_VAL = 32'h0002_0100;
  localparam logic [DATA_W-1:0] MAGIC_VAL   = 32'h601A_3471;

  // addr_i[7:6] selects the bank, addr_i[5:2] selects the channel
  typedef enum logic [1:0] {
    BANK_GLOBAL = 2'b00,
    BANK_PERIOD = 2'b01,
    BANK_HIGH   = 2'b10,
    BANK_DELAY  = 2'b11
  } bank_e;

  typedef struct packed {
    logic [DATA_W-1:0] period;
    logic [DATA_W-1:0] high;
    logic [DATA_W-1:0] delay;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [DATA_W-1:0] ID_VAL = 32'h0000_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output chan_cfg_t         stage_o [NUM_CH],
  output logic              hold_o,
  output logic              align_o,
  output logic              load_o
);
  localparam int IDX_W = 4;

  logic [DATA_W-1:0] scratch_q;
  logic              hold_q, align_q;
  chan_cfg_t         stage_q [NUM_CH];

  logic              aligned, wr, rd;
  bank_e             bank;
  logic [IDX_W-1:0]  idx;
  logic              idx_ok;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i && we_i && aligned;
  assign rd      = req_i && !we_i && aligned;
  assign bank    = bank_e'(addr_i[7:6]);
  assign idx     = addr_i[5:2];
  assign idx_ok  = int'(idx) < NUM_CH;

  assign load_o  = wr && (addr_i == A_CTRL) && wdata_i[1];
  assign hold_o  = hold_q;
  assign align_o = align_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      hold_q    <= 1'b1;
      align_q   <= 1'b0;
    end else if (wr && bank == BANK_GLOBAL) begin
      case (addr_i)
        A_SCRATCH: scratch_q <= wdata_i;
        A_CTRL:    hold_q    <= wdata_i[0];
        A_CONFIG:  align_q   <= wdata_i[1];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g] <= '0;
      end else if (wr && int'(idx) == g) begin
        case (bank)
          BANK_PERIOD: stage_q[g].period <= wdata_i;
          BANK_HIGH:   stage_q[g].high   <= wdata_i;
          BANK_DELAY:  stage_q[g].delay  <= wdata_i;
          default: ;
        endcase
      end
    end
    assign stage_o[g] = stage_q[g];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bank == BANK_GLOBAL) begin
      case (addr_i)
        A_VERSION: rd_mux = VERSION_VAL;
        A_IDENT:   rd_mux = ID_VAL;
        A_SCRATCH: rd_mux = scratch_q;
        A_MAGIC:   rd_mux = MAGIC_VAL;
        A_CTRL:    rd_mux = {{(DATA_W-1){1'b0}}, hold_q};
        A_NCHAN:   rd_mux = DATA_W'(NUM_CH);
        A_CONFIG:  rd_mux = {{(DATA_W-2){1'b0}}, align_q, 1'b0};
        default:   rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (idx_ok && int'(idx) == i) begin
          case (bank)
            BANK_PERIOD: rd_mux = stage_q[i].period;
            BANK_HIGH:   rd_mux = stage_q[i].high;
            BANK_DELAY:  rd_mux = stage_q[i].delay;
            default:     rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  assert_load_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_CTRL) |=> (rdata_o[1] == 1'b0));
endmodule

// File: rtl/pwm_bank_sync.sv
module pwm_bank_sync #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              align_i,
  input  logic              hold_i,
  input  logic [NUM_CH-1:0] wrap_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic              apply_o
);
  logic              pending_q;
  logic [NUM_CH-1:0] done_q;
  logic              all_done;

  assign all_done = &(done_q | wrap_i | ~en_i);

  always_comb begin
    if (hold_i || align_i) apply_o = load_i;
    else                   apply_o = pending_q && all_done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      done_q    <= '0;
    end else if (hold_i) begin
      pending_q <= 1'b0;
      done_q    <= '0;
    end else if (load_i && !align_i) begin
      pending_q <= 1'b1;
      done_q    <= '0;
    end else if (apply_o) begin
      pending_q <= 1'b0;
      done_q    <= '0;
    end else if (pending_q) begin
      done_q    <= done_q | wrap_i;
    end
  end

  // a deferred apply can only follow a load that was held
  assert_defer_needs_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!align_i && !hold_i && !load_i && apply_o) |-> pending_q);
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  logic      apply_i,
  input  chan_cfg_t stage_i,
  output logic      en_o,
  output logic      wrap_o,
  output logic      pwm_o
);
  chan_cfg_t         live_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W:0]   high_end;

  assign en_o     = !hold_i && (live_q.period != '0);
  assign wrap_o   = en_o && (cnt_q == live_q.period - 1'b1);
  assign high_end = {1'b0, live_q.delay} + {1'b0, live_q.high};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      live_q <= '0;
    else if (apply_i) live_q <= stage_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_o || apply_i)  cnt_q <= '0;
    else if (wrap_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // cnt_q < period always, so the window is clipped at the period end
  assign pwm_o = en_o && (live_q.delay < live_q.period) &&
                 (cnt_q >= live_q.delay) && ({1'b0, cnt_q} < high_end);

  assert_cnt_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (cnt_q < live_q.period));
  assert_restart_on_apply_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> (cnt_q == '0));
  assert_live_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(live_q));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [31:0] ID_VAL = 32'h0000_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  chan_cfg_t         stage [NUM_CH];
  logic              hold, align, load, apply;
  logic [NUM_CH-1:0] en, wrap;

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ID_VAL(ID_VAL)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .stage_o (stage),
    .hold_o  (hold),
    .align_o (align),
    .load_o  (load)
  );

  pwm_bank_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .align_i (align),
    .hold_i  (hold),
    .wrap_i  (wrap),
    .en_i    (en),
    .apply_o (apply)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    pwm_bank_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hold_i  (hold),
      .apply_i (apply),
      .stage_i (stage[g]),
      .en_o    (en[g]),
      .wrap_o  (wrap[g]),
      .pwm_o   (pwm_o[g])
    );
  end

  assert_hold_forces_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> (pwm_o == '0));
  assert_low_after_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pwm_o == '0));
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int NUM_CH = 4;
  localparam logic [31:0] ID_VAL = 32'h0000_00A5;
  localparam int NV = 8;
  // period, high time, delay
  localparam int unsigned VP [NV] = '{4, 5, 6, 3, 4, 7, 1, 6};
  localparam int unsigned VD [NV] = '{2, 1, 3, 9, 2, 0, 1, 2};
  localparam int unsigned VO [NV] = '{0, 2, 4, 0, 4, 3, 0, 5};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] pwm;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_bank #(.NUM_CH(NUM_CH), .ID_VAL(ID_VAL)) u_pwm_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic check(input logic ok, input string req_tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic set_chan(input int ch, input int unsigned p,
                          input int unsigned d, input int unsigned o);
    bus_write(8'h40 + 8'(4 * ch), p);
    bus_write(8'h80 + 8'(4 * ch), d);
    bus_write(8'hC0 + 8'(4 * ch), o);
  endtask

  function automatic logic expect_high(input int unsigned p, input int unsigned d,
                                       input int unsigned o, input int unsigned k);
    int unsigned c;
    c = k % p;
    return (o < p) && (c >= o) && (c < o + d);
  endfunction

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int highs;

    repeat (3) @(negedge clk);
    check(pwm == '0, "R11 low in reset", 32'(pwm), 0);
    rst_ni = 1'b1;
    check(pwm == '0, "R11 low after reset", 32'(pwm), 0);

    bus_read(8'h10, rd); check(rd == 32'h1, "R3 ctrl reset", rd, 1);
    bus_read(8'h18, rd); check(rd == 32'h0, "R3 config reset", rd, 0);
    bus_read(8'h00, rd); check(rd[23:16] == 8'd2, "R1 version major", 32'(rd[23:16]), 2);
    bus_read(8'h04, rd); check(rd == ID_VAL, "R1 id", rd, ID_VAL);
    bus_read(8'h0C, rd); check(rd == 32'h601A3471, "R1 magic", rd, 32'h601A3471);
    bus_read(8'h14, rd); check(rd == NUM_CH, "R1 channel count", rd, NUM_CH);
    bus_write(8'h08, 32'hDEAD_BEEF);
    bus_read(8'h08, rd); check(rd == 32'hDEAD_BEEF, "R2 scratch", rd, 32'hDEAD_BEEF);
    bus_write(8'h08, 32'h1234_5678);
    bus_read(8'h08, rd); check(rd == 32'h1234_5678, "R2 scratch rewrite", rd, 32'h1234_5678);

    // R9: core held in reset keeps outputs low even with a loaded channel
    bus_write(8'h18, 32'h2);
    set_chan(0, 2, 2, 0);
    bus_write(8'h10, 32'h3);
    for (int k = 0; k < 4; k++) begin
      check(pwm == '0, "R9 hold low", 32'(pwm), 0);
      @(negedge clk);
    end
    bus_read(8'h10, rd); check(rd == 32'h1, "R3 load bit reads 0", rd, 1);
    bus_write(8'h10, 32'h0);
    check(pwm[3] == 1'b0, "R9 period zero low", 32'(pwm[3]), 0);

    // table walk on channel 0 (R6, R7, R8)
    for (int v = 0; v < NV; v++) begin
      set_chan(0, VP[v], VD[v], VO[v]);
      bus_write(8'h10, 32'h2);
      for (int k = 0; k < 2 * int'(VP[v]); k++) begin
        if (k != 0) @(negedge clk);
        check(pwm[0] == expect_high(VP[v], VD[v], VO[v], k), "R6/R7/R8 window",
              32'(pwm[0]), 32'(expect_high(VP[v], VD[v], VO[v], k)));
      end
    end

    // R5: reload mid-period restarts channels of different periods together
    set_chan(0, 4, 1, 0);
    set_chan(1, 6, 1, 0);
    bus_write(8'h10, 32'h2);
    repeat (5) @(negedge clk);
    bus_write(8'h10, 32'h2);
    check(pwm[1:0] == 2'b11, "R5 aligned index 0", 32'(pwm[1:0]), 3);
    @(negedge clk);
    check(pwm[1:0] == 2'b00, "R5 aligned index 1", 32'(pwm[1:0]), 0);

    // R4: staged writes do not reach the output
    set_chan(0, 2, 2, 0);
    bus_read(8'h40, rd); check(rd == 2, "R4 period readback", rd, 2);
    bus_read(8'h80, rd); check(rd == 2, "R4 high readback", rd, 2);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (pwm[0]) highs++;
    end
    check(highs == 2, "R4 staged no effect", 32'(highs), 2);
    bus_write(8'h10, 32'h2);
    for (int k = 0; k < 4; k++) begin
      check(pwm[0] == 1'b1, "R4 applied after load", 32'(pwm[0]), 1);
      @(negedge clk);
    end

    // R10: deferred load
    set_chan(1, 0, 0, 0);
    set_chan(2, 0, 0, 0);
    set_chan(3, 0, 0, 0);
    set_chan(0, 8, 1, 0);
    bus_write(8'h10, 32'h2);   // edge E, index 0 after it
    check(pwm[0] == 1'b1, "R10 setup index 0", 32'(pwm[0]), 1);
    bus_write(8'h18, 32'h0);   // E+2
    bus_write(8'h40, 32'h2);   // E+4
    bus_write(8'h80, 32'h2);   // E+6
    bus_write(8'h10, 32'h2);   // E+8: old period wraps on this same edge
    for (int k = 8; k < 20; k++) begin
      if (k != 8) @(negedge clk);
      check(pwm[0] == (k == 8 || k >= 16), "R10 deferred switch",
            32'(pwm[0]), 32'(k == 8 || k >= 16));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule